// File: doc/BRIEF.md
# I2C Clock and Condition Timing Sequencer

This block times the SCL line and the bus conditions for an I2C master. A bit engine hands it one command at a time: a start condition, one data bit slot, a stop condition or a repeated start. The sequencer drives SCL low or releases it, and raises single-cycle strobes at the moments the bit engine must act on SDA. These moments are: pull SDA low for a start, release it for a stop, and change the data bit. Every interval comes from packed timing words. There are two banks of words, one for standard/fast timing and one for high-speed timing, plus a shared data-hold word and a configuration word that holds the glitch-filter cycle count and the high-speed enable.

All intervals are counted in prescaled ticks. One tick is `div+1` input clocks, and `div` comes from the active bank. Each edge of SCL in a bit slot also carries a fixed pad of `4 + filter` input clocks. A complete bit period is therefore `(div+1)*(lo+hi+2) + 8 + 2*filter` input clocks. When high-speed operation is enabled, the transfer opens on the fast bank and switches to the high-speed bank at the first repeated start. It returns to the fast bank once a stop completes.

Top module: `scl_timing_gen`

## Requirements
- R1: One cycle after `rst` or `soft_rst` is high at a clock edge, `cmd_ready` is 1, `scl_low` is 0 and no strobe is high. A command in progress is abandoned.
- R2: A command is taken only at an edge where `cmd_valid` and `cmd_ready` are both 1, with `cmd_code` 0=start, 1=bit, 2=stop, 3=repeated start. `cmd_ready` is 0 from the cycle after acceptance up to and including the cycle with `ev_done`, and is 1 in the next cycle. `cmd_valid` while busy has no effect on any output.
- R3: A timing field of value v lasts (v+1)*(div+1) clocks, with div = bits 23:16 of the third word of the selected bank.
- R4: In a bit command, SCL is low from cycle 1 after acceptance for P+(lo+1)*(div+1) cycles and then released for P+(hi+1)*(div+1) cycles. P = 4+F, F = `cfg_word[18:16]`, lo = word2[15:8], hi = word2[7:0]. `ev_done` is in the last released cycle.
- R5: In the SCL-low part of a bit, stop or repeated start, `ev_sda_change` pulses once, at the end of tick index k after the pad. k = min(hold, lim), hold = `hold_word[7:0]`, lim = lo-su_d, or 0 when su_d > lo, and su_d = word2[31:24].
- R6: A start keeps SCL released. `ev_sda_low` pulses after (ss+1) ticks, with ss = word1[31:24]. `ev_done` follows (sh+1) ticks later, with sh = word1[23:16].
- R7: A stop runs the bit low phase, then releases SCL for (ps+1) ticks with ps = word1[15:8]. `ev_sda_high` and `ev_done` pulse together in its last cycle.
- R8: A repeated start runs the bit low phase, releases SCL for (rr+1) ticks with rr = word3[7:0], then runs the start sequence of R6.
- R9: With `cfg_word[29]` = 0 every command uses the fast bank. With it set, the high-speed bank is used from the acceptance of a repeated start until the next stop completes, and the fast bank is used otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous software reset, same effect as rst |
| cfg_word | input | 32 | Filter count [18:16], high-speed enable [29] |
| fs_word1 | input | 32 | Fast bank: start setup, start hold, stop setup |
| fs_word2 | input | 32 | Fast bank: data setup, SCL low, SCL high |
| fs_word3 | input | 32 | Fast bank: divider, repeated-start release |
| hs_word1 | input | 32 | High-speed bank word 1 |
| hs_word2 | input | 32 | High-speed bank word 2 |
| hs_word3 | input | 32 | High-speed bank word 3 |
| hold_word | input | 32 | Data hold count [7:0] |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | Command code |
| cmd_ready | output | 1 | Idle and able to take a command |
| scl_low | output | 1 | Drive SCL low |
| ev_sda_change | output | 1 | Bit engine may change SDA |
| ev_sda_low | output | 1 | Pull SDA low (start condition) |
| ev_sda_high | output | 1 | Release SDA (stop condition) |
| ev_done | output | 1 | Last cycle of the command |

## Verification
The bench builds the block with its default parameters: 8-bit fields, a 3-bit filter count and a base pad of 4. It programs small field values so that every phase boundary falls within a few dozen cycles. Dividers of 0, 1 and 3 and filter counts of 0, 2 and 7 reach both tick spacing and pad length extremes. A hold above the low count and a data setup above the low count reach both clamps of the change strobe. With high-speed enabled, sequences open on the fast bank, switch at a repeated start and return after a stop. A software reset is applied mid-bit.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 8;
    localparam int FLT_W   = 3;

    typedef enum logic [1:0] {
        CMD_START   = 2'd0,
        CMD_BIT     = 2'd1,
        CMD_STOP    = 2'd2,
        CMD_RESTART = 2'd3
    } cmd_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LO_PAD,
        PH_LO_TK,
        PH_HI_PAD,
        PH_HI_TK,
        PH_START_SU,
        PH_START_HD,
        PH_STOP_SU,
        PH_RELEASE
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] div;
        logic [FIELD_W-1:0] scl_lo;
        logic [FIELD_W-1:0] scl_hi;
        logic [FIELD_W-1:0] start_su;
        logic [FIELD_W-1:0] start_hd;
        logic [FIELD_W-1:0] stop_su;
        logic [FIELD_W-1:0] release_t;
        logic [FIELD_W-1:0] dat_su;
    } bank_t;

    function automatic bank_t unpack_bank(input logic [WORD_W-1:0] w1,
                                          input logic [WORD_W-1:0] w2,
                                          input logic [WORD_W-1:0] w3);
        bank_t b;
        b.start_su  = w1[31:24];
        b.start_hd  = w1[23:16];
        b.stop_su   = w1[15:8];
        b.dat_su    = w2[31:24];
        b.scl_lo    = w2[15:8];
        b.scl_hi    = w2[7:0];
        b.div       = w3[23:16];
        b.release_t = w3[7:0];
        return b;
    endfunction

    // Tick index inside the low phase where SDA may change.
    function automatic logic [FIELD_W-1:0] change_index(input logic [FIELD_W-1:0] lo,
                                                        input logic [FIELD_W-1:0] su_d,
                                                        input logic [FIELD_W-1:0] hold);
        logic [FIELD_W-1:0] lim;
        lim = (su_d > lo) ? '0 : lo - su_d;
        return (hold < lim) ? hold : lim;
    endfunction

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
    import scl_tgen_pkg::*;
#(
    parameter int DIV_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (run && tick && div != '0) |=> !tick); // R3

endmodule

// File: rtl/scl_bank_sel.sv
module scl_bank_sel
    import scl_tgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hs_en,
    input  logic  accept,
    input  cmd_e  cmd,
    input  logic  stop_done,
    input  bank_t fs_bank,
    input  bank_t hs_bank,
    output bank_t sel_bank,
    output logic  use_hs
);

    logic hs_active;

    assign use_hs   = hs_en && (hs_active || cmd == CMD_RESTART);
    assign sel_bank = use_hs ? hs_bank : fs_bank;

    always_ff @(posedge clk) begin
        if (rst || stop_done) begin
            hs_active <= 1'b0;
        end else if (accept && cmd == CMD_RESTART && hs_en) begin
            hs_active <= 1'b1;
        end
    end

    AST_START_ON_FAST: assert property (@(posedge clk) disable iff (rst)
        (stop_done) |=> !hs_active); // R9

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_tgen_pkg::*;
#(
    parameter int PAD_BASE = 4,
    localparam int PAD_W   = $clog2(PAD_BASE + (1 << FLT_W) + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  cmd_e               cmd,
    input  bank_t              sel_bank,
    input  logic [FIELD_W-1:0] hold,
    input  logic [FLT_W-1:0]   filt,
    input  logic               tick,
    output logic               cmd_ready,
    output logic               accept,
    output logic               run,
    output logic [FIELD_W-1:0] div_q,
    output logic               scl_low,
    output logic               ev_sda_change,
    output logic               ev_sda_low,
    output logic               ev_sda_high,
    output logic               ev_done
);

    phase_e             ph;
    cmd_e               cmd_q;
    bank_t              bk_q;
    logic [FIELD_W-1:0] chg_q;
    logic [PAD_W-1:0]   pad_last_q;
    logic [PAD_W-1:0]   pad;
    logic [FIELD_W-1:0] tk;
    logic [FIELD_W-1:0] cur_lim;
    logic               tk_end;
    logic               pad_end;
    logic               pad_ph;

    assign cmd_ready = (ph == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign div_q     = bk_q.div;
    assign scl_low   = (ph == PH_LO_PAD) || (ph == PH_LO_TK);
    assign pad_ph    = (ph == PH_LO_PAD) || (ph == PH_HI_PAD);
    assign run       = !pad_ph && (ph != PH_IDLE);

    always_comb begin
        unique case (ph)
            PH_LO_TK:    cur_lim = bk_q.scl_lo;
            PH_HI_TK:    cur_lim = bk_q.scl_hi;
            PH_START_SU: cur_lim = bk_q.start_su;
            PH_START_HD: cur_lim = bk_q.start_hd;
            PH_STOP_SU:  cur_lim = bk_q.stop_su;
            PH_RELEASE:  cur_lim = bk_q.release_t;
            default:     cur_lim = '0;
        endcase
    end

    assign tk_end  = run && tick && (tk == cur_lim);
    assign pad_end = pad_ph && (pad == pad_last_q);

    assign ev_sda_change = (ph == PH_LO_TK) && tick && (tk == chg_q);
    assign ev_sda_low    = (ph == PH_START_SU) && tk_end;
    assign ev_sda_high   = (ph == PH_STOP_SU) && tk_end;
    assign ev_done       = tk_end && ((ph == PH_HI_TK) || (ph == PH_START_HD)
                                      || (ph == PH_STOP_SU));

    // Command capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= CMD_START;
            bk_q       <= '0;
            chg_q      <= '0;
            pad_last_q <= '0;
        end else if (accept) begin
            cmd_q      <= cmd;
            bk_q       <= sel_bank;
            chg_q      <= change_index(sel_bank.scl_lo, sel_bank.dat_su, hold);
            pad_last_q <= PAD_W'(PAD_BASE) + PAD_W'(filt) - 1'b1;
        end
    end

    // Interval counters
    always_ff @(posedge clk) begin
        if (rst || pad_end || !pad_ph) begin
            pad <= '0;
        end else begin
            pad <= pad + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || tk_end || !run) begin
            tk <= '0;
        end else if (tick) begin
            tk <= tk + 1'b1;
        end
    end

    // Phase sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
        end else begin
            unique case (ph)
                PH_IDLE:     if (accept) ph <= (cmd == CMD_START) ? PH_START_SU : PH_LO_PAD;
                PH_LO_PAD:   if (pad_end) ph <= PH_LO_TK;
                PH_LO_TK: begin
                    if (tk_end) begin
                        unique case (cmd_q)
                            CMD_BIT:  ph <= PH_HI_PAD;
                            CMD_STOP: ph <= PH_STOP_SU;
                            default:  ph <= PH_RELEASE;
                        endcase
                    end
                end
                PH_HI_PAD:   if (pad_end) ph <= PH_HI_TK;
                PH_HI_TK:    if (tk_end) ph <= PH_IDLE;
                PH_START_SU: if (tk_end) ph <= PH_START_HD;
                PH_START_HD: if (tk_end) ph <= PH_IDLE;
                PH_STOP_SU:  if (tk_end) ph <= PH_IDLE;
                PH_RELEASE:  if (tk_end) ph <= PH_START_SU;
                default:     ph <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> cmd_ready); // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cmd_ready); // R2
    AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ev_sda_high |-> ev_done); // R7
    AST_ONE_SDA_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_sda_change, ev_sda_low, ev_sda_high})); // R5
    AST_CHANGE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        ev_sda_change |=> scl_low || $past(tk_end)); // R5

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tgen_pkg::*;
#(
    parameter int PAD_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [WORD_W-1:0] fs_word1,
    input  logic [WORD_W-1:0] fs_word2,
    input  logic [WORD_W-1:0] fs_word3,
    input  logic [WORD_W-1:0] hs_word1,
    input  logic [WORD_W-1:0] hs_word2,
    input  logic [WORD_W-1:0] hs_word3,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    output logic              cmd_ready,
    output logic              scl_low,
    output logic              ev_sda_change,
    output logic              ev_sda_low,
    output logic              ev_sda_high,
    output logic              ev_done
);

    logic               rst_all;
    bank_t              fs_bank;
    bank_t              hs_bank;
    bank_t              sel_bank;
    logic               use_hs;
    logic               accept;
    logic               run;
    logic               tick;
    logic [FIELD_W-1:0] div_q;
    cmd_e               cmd;

    assign rst_all = rst || soft_rst;
    assign cmd     = cmd_e'(cmd_code);
    assign fs_bank = unpack_bank(fs_word1, fs_word2, fs_word3);
    assign hs_bank = unpack_bank(hs_word1, hs_word2, hs_word3);

    scl_bank_sel u_bank (
        .clk       (clk),
        .rst       (rst_all),
        .hs_en     (cfg_word[29]),
        .accept    (accept),
        .cmd       (cmd),
        .stop_done (ev_sda_high),
        .fs_bank   (fs_bank),
        .hs_bank   (hs_bank),
        .sel_bank  (sel_bank),
        .use_hs    (use_hs)
    );

    scl_tick_gen #(.DIV_W(FIELD_W)) u_tick (
        .clk  (clk),
        .rst  (rst_all),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    scl_phase_seq #(.PAD_BASE(PAD_BASE)) u_seq (
        .clk           (clk),
        .rst           (rst_all),
        .cmd_valid     (cmd_valid),
        .cmd           (cmd),
        .sel_bank      (sel_bank),
        .hold          (hold_word[FIELD_W-1:0]),
        .filt          (cfg_word[18:16]),
        .tick          (tick),
        .cmd_ready     (cmd_ready),
        .accept        (accept),
        .run           (run),
        .div_q         (div_q),
        .scl_low       (scl_low),
        .ev_sda_change (ev_sda_change),
        .ev_sda_low    (ev_sda_low),
        .ev_sda_high   (ev_sda_high),
        .ev_done       (ev_done)
    );

    AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cmd_ready && !scl_low && !ev_done)); // R1
    AST_FAST_WHEN_OFF: assert property (@(posedge clk) disable iff (rst_all)
        (accept && !cfg_word[29]) |-> !use_hs); // R9

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int EV_FALL = 0, EV_RISE = 1, EV_CHG = 2, EV_SLOW = 3, EV_SHIGH = 4, EV_DONE = 5;

    logic        clk = 0, rst = 1, soft_rst = 0;
    logic [31:0] cfg_word, fs_word1, fs_word2, fs_word3, hs_word1, hs_word2, hs_word3, hold_word;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_code = 0;
    logic        cmd_ready, scl_low, ev_sda_change, ev_sda_low, ev_sda_high, ev_done;

    scl_timing_gen uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int checks = 0, errors = 0;
    int exp_t[$];
    int exp_c[$];
    string exp_r[$];
    logic prev_scl = 0;
    bit hs_act = 0;

    // bench-side register model: [0]=fast, [1]=high-speed
    int bdiv[2], blo[2], bhi[2], bss[2], bsh[2], bps[2], brr[2], bsd[2];
    int hold_v, filt_v;
    bit hs_en;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic apply_cfg();
        cfg_word  = (32'(hs_en) << 29) | (32'(filt_v) << 16);
        fs_word1  = (32'(bss[0]) << 24) | (32'(bsh[0]) << 16) | (32'(bps[0]) << 8);
        fs_word2  = (32'(bsd[0]) << 24) | (32'(blo[0]) << 8) | 32'(bhi[0]);
        fs_word3  = (32'(bdiv[0]) << 16) | 32'(brr[0]);
        hs_word1  = (32'(bss[1]) << 24) | (32'(bsh[1]) << 16) | (32'(bps[1]) << 8);
        hs_word2  = (32'(bsd[1]) << 24) | (32'(blo[1]) << 8) | 32'(bhi[1]);
        hs_word3  = (32'(bdiv[1]) << 16) | 32'(brr[1]);
        hold_word = 32'(hold_v);
    endtask

    task automatic push(input int t, input int c, input string r);
        exp_t.push_back(t); exp_c.push_back(c); exp_r.push_back(r);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_scl <= scl_low;
        end else begin
            bit obs [6];
            obs[EV_FALL]  = scl_low && !prev_scl;
            obs[EV_RISE]  = !scl_low && prev_scl;
            obs[EV_CHG]   = ev_sda_change;
            obs[EV_SLOW]  = ev_sda_low;
            obs[EV_SHIGH] = ev_sda_high;
            obs[EV_DONE]  = ev_done;
            while (exp_t.size() > 0 && exp_t[0] < cyc) begin
                chk(0, {exp_r[0], " missing event"}, exp_c[0], exp_t[0]);
                void'(exp_t.pop_front()); void'(exp_c.pop_front()); void'(exp_r.pop_front());
            end
            for (int k = 0; k < 6; k++) begin
                if (obs[k]) begin
                    if (exp_t.size() > 0 && exp_t[0] == cyc && exp_c[0] == k) begin
                        chk(1, exp_r[0], k, k);
                        void'(exp_t.pop_front()); void'(exp_c.pop_front()); void'(exp_r.pop_front());
                    end else begin
                        chk(0, "unexpected event code", k, (exp_c.size() > 0) ? exp_c[0] : -1);
                    end
                end
            end
            prev_scl <= scl_low;
        end
    end

    function automatic int chg_idx(input int lo, input int sd, input int hd);
        int lim;
        lim = (sd > lo) ? 0 : lo - sd;
        return (hd < lim) ? hd : lim;
    endfunction

    // Driver: issues one command and pushes its expected events
    task automatic issue(input int code, input bit poke);
        int b, c, d, p, lowend, base;
        b = (hs_en && (hs_act || code == 3)) ? 1 : 0;   // R9
        if (code == 3 && hs_en) hs_act = 1;
        d = bdiv[b] + 1;
        p = 4 + filt_v;
        @(negedge clk);
        cmd_code = 2'(code);
        cmd_valid = 1;
        c = cyc;
        lowend = c + p + (blo[b] + 1) * d;
        if (code == 0) begin
            push(c + (bss[b] + 1) * d, EV_SLOW, "R6 start sda low");
            push(c + (bss[b] + bsh[b] + 2) * d, EV_DONE, "R6 start done");
        end else begin
            push(c + 1, EV_FALL, "R4 scl fall");
            push(c + p + (chg_idx(blo[b], bsd[b], hold_v) + 1) * d, EV_CHG, "R5 sda change");
            push(lowend + 1, EV_RISE, "R4 scl rise");
            if (code == 1) begin
                push(lowend + p + (bhi[b] + 1) * d, EV_DONE, "R4 bit done");
            end else if (code == 2) begin
                push(lowend + (bps[b] + 1) * d, EV_SHIGH, "R7 stop sda high");
                push(lowend + (bps[b] + 1) * d, EV_DONE, "R7 stop done");
            end else begin
                base = lowend + (brr[b] + 1) * d;
                push(base + (bss[b] + 1) * d, EV_SLOW, "R8 restart sda low");
                push(base + (bss[b] + bsh[b] + 2) * d, EV_DONE, "R8 restart done");
            end
        end
        @(negedge clk);
        cmd_valid = 0;
        chk(cmd_ready == 0, "R2 busy after accept", int'(cmd_ready), 0);
        if (poke) begin
            cmd_code = 2'(code ^ 1);
            cmd_valid = 1;                    // R2: ignored while busy
            @(negedge clk);
            @(negedge clk);
            cmd_valid = 0;
        end
        while (!cmd_ready) @(negedge clk);
        if (code == 2) hs_act = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bdiv[0] = 1; blo[0] = 5; bhi[0] = 4; bss[0] = 3; bsh[0] = 2; bps[0] = 3; brr[0] = 4; bsd[0] = 1;
        bdiv[1] = 0; blo[1] = 2; bhi[1] = 1; bss[1] = 1; bsh[1] = 1; bps[1] = 1; brr[1] = 1; bsd[1] = 0;
        hold_v = 2; filt_v = 2; hs_en = 0;
        apply_cfg();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready == 1, "R1 ready after reset", int'(cmd_ready), 1);
        chk(scl_low == 0, "R1 scl released after reset", int'(scl_low), 0);

        // Fast-only frame, with a busy-time request that must be ignored
        issue(0, 0); issue(1, 0); issue(1, 1); issue(2, 0);
        // Repeated start with high-speed disabled stays on fast bank
        issue(0, 0); issue(1, 0); issue(3, 0); issue(1, 0); issue(2, 0);

        // High-speed frame: fast until repeated start, then high-speed until stop
        hs_en = 1; apply_cfg();
        issue(0, 0); issue(1, 0); issue(3, 0); issue(1, 1); issue(1, 0); issue(2, 0);
        issue(0, 0); issue(1, 0); issue(2, 0);
        hs_en = 0; apply_cfg();

        // Change index clamps: hold above limit, then setup above low count
        hold_v = 9; apply_cfg(); issue(1, 0);
        bsd[0] = 7; apply_cfg(); issue(1, 0);
        bsd[0] = 1; hold_v = 0; apply_cfg(); issue(1, 0);

        // Filter pad extremes and a larger divider
        filt_v = 7; apply_cfg(); issue(1, 0);
        filt_v = 0; bdiv[0] = 3; apply_cfg(); issue(0, 0); issue(1, 0); issue(2, 0);

        // Soft reset in the middle of a bit
        begin
            int c, s;
            @(negedge clk);
            cmd_code = 2'd1; cmd_valid = 1; c = cyc;
            push(c + 1, EV_FALL, "R4 scl fall before soft reset");
            @(negedge clk);
            cmd_valid = 0;
            @(negedge clk);
            @(negedge clk);
            soft_rst = 1; s = cyc;
            exp_t.delete(); exp_c.delete(); exp_r.delete();
            push(s + 1, EV_RISE, "R1 scl released by soft reset");
            @(negedge clk);
            soft_rst = 0;
            chk(cmd_ready == 1, "R1 ready after soft reset", int'(cmd_ready), 1);
            chk(scl_low == 0, "R1 scl high after soft reset", int'(scl_low), 0);
            hs_act = 0;
        end
        issue(0, 0); issue(2, 0);

        repeat (5) @(negedge clk);
        chk(exp_t.size() == 0, "R2 all expected events seen", exp_t.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule